// File: doc/BRIEF.md
# Configurable Pipeline Hazard Controller

This block decides, cycle by cycle, how a five-stage in-order integer pipeline keeps its results correct. The five stages run in this order: fetch, decode, execute, memory, writeback. The controller compares the two source register indices of the instruction in decode with the destination indices of the instructions in execute, memory and writeback. From that comparison it picks an operand bypass source for each operand, or it holds fetch and decode and sends a bubble into execute. It also takes the taken signals for branches and jumps from the stages that resolve them. It then clears every younger stage in the same cycle and raises a redirect strobe one cycle later, which tells fetch to load the new target.

Three build-time options shape the behaviour:
- `USE_BYPASS` chooses between operand bypassing and stall-only operation.
- `BR_AT_WB` moves branch resolution from the memory stage to writeback.
- `JMP_AT_MEM` moves jump resolution from the execute stage to the memory stage.

The stage that resolves a redirect sets how deep the flush reaches. The datapath must place its bypass multiplexers and stage-clear logic to match these outputs.

Top module: `hazard_ctrl`

## Requirements
- R1: Register index 0 never causes a stall and is never chosen as a bypass source, whatever the producer stages carry.
- R2: With bypassing enabled, each operand select uses this encoding: 0 means register file, 1 means execute, 2 means memory and 3 means writeback. Only a producer with its write enable set and a matching destination counts. When several producers match, the youngest wins: execute first, then memory, then writeback.
- R3: With bypassing enabled, a load in execute whose destination matches either decode source raises `stall_f`, `stall_d` and `bubble_e` in the same cycle. A producer in execute that is not a load causes no stall.
- R4: With bypassing disabled, both selects stay 0. The stall outputs stay high in every cycle in which any write-enabled producer in execute, memory or writeback matches a decode source.
- R5: `squash` bit 0 clears fetch, bit 1 clears decode, bit 2 clears execute and bit 3 clears memory. A taken redirect sets every bit below its resolving stage, combinationally, in the same cycle. With no redirect, `squash` is 0.
- R6: A taken branch gives `squash` = 4'b0111 by default (memory-stage resolution), and 4'b1111 when `BR_AT_WB` is set.
- R7: A taken jump gives `squash` = 4'b0011 by default (execute-stage resolution), and 4'b0111 when `JMP_AT_MEM` is set. When a branch and a jump are taken together, `squash` is the union of their two masks.
- R8: A flush overrides a stall: while `squash` is non-zero, `stall_f`, `stall_d` and `bubble_e` are low.
- R9: `redir_vld` is high in exactly the cycle after a cycle with a taken branch or jump. In that cycle `redir_is_br` is 1 if a branch was among the taken redirects, because the branch is the older instruction.
- R10: While reset is asserted, `redir_vld` and `redir_is_br` stay 0, even if taken signals are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_rs1 | input | 5 | First source index of the instruction in decode |
| dec_rs2 | input | 5 | Second source index of the instruction in decode |
| ex_rd | input | 5 | Destination index in execute |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | 5 | Destination index in memory |
| mem_we | input | 1 | Memory instruction writes a register |
| wb_rd | input | 5 | Destination index in writeback |
| wb_we | input | 1 | Writeback instruction writes a register |
| br_taken | input | 1 | Branch in its resolving stage is taken |
| jmp_taken | input | 1 | Jump in its resolving stage is taken |
| byp_sel_a | output | 2 | Bypass source for operand 1 (R2 encoding) |
| byp_sel_b | output | 2 | Bypass source for operand 2 (R2 encoding) |
| stall_f | output | 1 | Hold the fetch stage |
| stall_d | output | 1 | Hold the decode stage |
| bubble_e | output | 1 | Insert a bubble into execute |
| squash | output | 4 | Per-stage clear, one bit per stage (R5 bit layout) |
| redir_vld | output | 1 | Fetch redirect strobe, one cycle after a taken redirect |
| redir_is_br | output | 1 | The redirect came from a branch |

## Verification
A data hazard stall and a redirect flush can fall in the same cycle. Examples are a load-use match in decode while a jump is taken, or a pending stall-only match while a branch resolves. The bench builds those vectors so that the hazard alone would raise the stall outputs. It then judges that the stall outputs stay low, while `squash` carries the resolving stage's mask for the active configuration. Two instances are driven together, one with default options and one with stall-only operation and late resolution, so that each coincidence is judged under both flush depths.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

    // Operand source encoding for the bypass multiplexers
    typedef enum logic [1:0] {
        BYP_RF  = 2'd0,
        BYP_EX  = 2'd1,
        BYP_MEM = 2'd2,
        BYP_WB  = 2'd3
    } byp_sel_e;

    // Pipeline stage positions, oldest-last
    localparam int STG_F = 0;
    localparam int STG_D = 1;
    localparam int STG_E = 2;
    localparam int STG_M = 3;
    localparam int STG_W = 4;

    // Number of stages that can be cleared by a redirect
    localparam int SQ_W = 4;

    typedef struct packed {
        logic vld;
        logic is_br;
    } redir_st_t;

endpackage

// File: rtl/hazard_bypass_pick.sv
module hazard_bypass_pick
    import hazard_pkg::*;
#(
    parameter int IDX_W      = 5,
    parameter bit USE_BYPASS = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] src_idx,
    input  logic [IDX_W-1:0] ex_rd,
    input  logic             ex_we,
    input  logic [IDX_W-1:0] mem_rd,
    input  logic             mem_we,
    input  logic [IDX_W-1:0] wb_rd,
    input  logic             wb_we,
    output logic [1:0]       sel
);

    logic src_live;
    logic hit_ex, hit_mem, hit_wb;

    assign src_live = (src_idx != '0);
    assign hit_ex   = src_live && ex_we  && (ex_rd  == src_idx);
    assign hit_mem  = src_live && mem_we && (mem_rd == src_idx);
    assign hit_wb   = src_live && wb_we  && (wb_rd  == src_idx);

    generate
        if (USE_BYPASS) begin : g_fwd
            always_comb begin
                if (hit_ex)       sel = BYP_EX;
                else if (hit_mem) sel = BYP_MEM;
                else if (hit_wb)  sel = BYP_WB;
                else              sel = BYP_RF;
            end
        end else begin : g_nofwd
            logic unused_hits;
            assign unused_hits = hit_ex ^ hit_mem ^ hit_wb;
            assign sel = BYP_RF;
        end
    endgenerate

    // R1: index 0 is never a bypass source
    p_x0_no_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (src_idx == '0) |-> (sel == BYP_RF));

    // R2: an execute pick needs a write-enabled matching producer
    p_ex_pick_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == BYP_EX) |-> (ex_we && ex_rd == src_idx));

    // R2: memory pick only when execute does not match
    p_mem_pick_young_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == BYP_MEM) |-> !(ex_we && ex_rd == src_idx) && mem_we);

    // R4: stall-only build never selects a bypass
    p_nofwd_rf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !USE_BYPASS |-> (sel == BYP_RF));

endmodule

// File: rtl/hazard_stall_detect.sv
module hazard_stall_detect #(
    parameter int IDX_W      = 5,
    parameter bit USE_BYPASS = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rs1,
    input  logic [IDX_W-1:0] rs2,
    input  logic [IDX_W-1:0] ex_rd,
    input  logic             ex_we,
    input  logic             ex_load,
    input  logic [IDX_W-1:0] mem_rd,
    input  logic             mem_we,
    input  logic [IDX_W-1:0] wb_rd,
    input  logic             wb_we,
    input  logic             flush_dec,
    output logic             hold_f,
    output logic             hold_d,
    output logic             bubble_e
);

    localparam int NPROD = 3;

    logic [IDX_W-1:0] prod_rd [NPROD];
    logic [NPROD-1:0] prod_we;
    logic [NPROD-1:0] prod_hit;
    logic             hazard;

    assign prod_rd[0] = ex_rd;
    assign prod_rd[1] = mem_rd;
    assign prod_rd[2] = wb_rd;
    assign prod_we    = {wb_we, mem_we, ex_we};

    for (genvar p = 0; p < NPROD; p++) begin : g_prod
        assign prod_hit[p] = prod_we[p] && (prod_rd[p] != '0) &&
                             ((prod_rd[p] == rs1) || (prod_rd[p] == rs2));
    end

    generate
        if (USE_BYPASS) begin : g_fwd
            // only a load still in execute has no value to bypass
            assign hazard = prod_hit[0] && ex_load;
        end else begin : g_nofwd
            logic unused_ld;
            assign unused_ld = ex_load;
            assign hazard    = |prod_hit;
        end
    endgenerate

    // a flush discards the held instruction, so it wins
    always_comb begin
        hold_f   = hazard && !flush_dec;
        hold_d   = hazard && !flush_dec;
        bubble_e = hazard && !flush_dec;
    end

    // R1: sources at index 0 never stall
    p_x0_no_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rs1 == '0 && rs2 == '0) |-> !hold_d);

    // R3: with bypassing, no load in execute means no stall
    p_fwd_nonload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (USE_BYPASS && !ex_load) |-> !hold_d);

    // R8: flush suppresses every stall output
    p_flush_no_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_dec |-> !(hold_f || hold_d || bubble_e));

endmodule

// File: rtl/hazard_redirect.sv
module hazard_redirect
    import hazard_pkg::*;
#(
    parameter bit BR_AT_WB   = 1'b0,
    parameter bit JMP_AT_MEM = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            br_taken,
    input  logic            jmp_taken,
    output logic [SQ_W-1:0] squash,
    output logic            redir_vld,
    output logic            redir_is_br
);

    localparam int BR_STG  = BR_AT_WB   ? STG_W : STG_M;
    localparam int JMP_STG = JMP_AT_MEM ? STG_M : STG_E;

    logic [SQ_W-1:0] br_mask, jmp_mask;
    redir_st_t       st_d, st_q;

    for (genvar k = 0; k < SQ_W; k++) begin : g_mask
        assign br_mask[k]  = (k < BR_STG);
        assign jmp_mask[k] = (k < JMP_STG);
    end

    assign squash = ({SQ_W{br_taken}} & br_mask) | ({SQ_W{jmp_taken}} & jmp_mask);

    always_comb begin
        st_d       = st_q;
        st_d.vld   = br_taken || jmp_taken;
        // a branch never resolves earlier than a jump, so it is older
        st_d.is_br = br_taken;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign redir_vld   = st_q.vld;
    assign redir_is_br = st_q.is_br;

    // R9: a taken redirect strobes fetch on the next cycle
    p_redir_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken || jmp_taken) |=> redir_vld);

    // R9: no strobe without a taken redirect in the cycle before
    p_redir_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(br_taken || jmp_taken) |=> !redir_vld);

    // R5: fetch is always cleared by any taken redirect
    p_squash_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken || jmp_taken) |-> squash[STG_F] && squash[STG_D]);

    // R6: branch source implies a strobe
    p_isbr_vld_r6: assert property (@(posedge clk) disable iff (!rst_n)
        redir_is_br |-> redir_vld);

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
    import hazard_pkg::*;
#(
    parameter int IDX_W      = 5,
    parameter bit USE_BYPASS = 1'b1,
    parameter bit BR_AT_WB   = 1'b0,
    parameter bit JMP_AT_MEM = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] dec_rs1,
    input  logic [IDX_W-1:0] dec_rs2,
    input  logic [IDX_W-1:0] ex_rd,
    input  logic             ex_we,
    input  logic             ex_load,
    input  logic [IDX_W-1:0] mem_rd,
    input  logic             mem_we,
    input  logic [IDX_W-1:0] wb_rd,
    input  logic             wb_we,
    input  logic             br_taken,
    input  logic             jmp_taken,
    output logic [1:0]       byp_sel_a,
    output logic [1:0]       byp_sel_b,
    output logic             stall_f,
    output logic             stall_d,
    output logic             bubble_e,
    output logic [3:0]       squash,
    output logic             redir_vld,
    output logic             redir_is_br
);

    localparam int NSRC = 2;

    logic [IDX_W-1:0] src_idx [NSRC];
    logic [1:0]       src_sel [NSRC];
    logic [SQ_W-1:0]  sq_vec;

    assign src_idx[0] = dec_rs1;
    assign src_idx[1] = dec_rs2;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        hazard_bypass_pick #(
            .IDX_W      (IDX_W),
            .USE_BYPASS (USE_BYPASS)
        ) u_pick (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_idx (src_idx[s]),
            .ex_rd   (ex_rd),
            .ex_we   (ex_we),
            .mem_rd  (mem_rd),
            .mem_we  (mem_we),
            .wb_rd   (wb_rd),
            .wb_we   (wb_we),
            .sel     (src_sel[s])
        );
    end

    assign byp_sel_a = src_sel[0];
    assign byp_sel_b = src_sel[1];

    hazard_redirect #(
        .BR_AT_WB   (BR_AT_WB),
        .JMP_AT_MEM (JMP_AT_MEM)
    ) u_redir (
        .clk         (clk),
        .rst_n       (rst_n),
        .br_taken    (br_taken),
        .jmp_taken   (jmp_taken),
        .squash      (sq_vec),
        .redir_vld   (redir_vld),
        .redir_is_br (redir_is_br)
    );

    assign squash = sq_vec;

    hazard_stall_detect #(
        .IDX_W      (IDX_W),
        .USE_BYPASS (USE_BYPASS)
    ) u_stall (
        .clk       (clk),
        .rst_n     (rst_n),
        .rs1       (dec_rs1),
        .rs2       (dec_rs2),
        .ex_rd     (ex_rd),
        .ex_we     (ex_we),
        .ex_load   (ex_load),
        .mem_rd    (mem_rd),
        .mem_we    (mem_we),
        .wb_rd     (wb_rd),
        .wb_we     (wb_we),
        .flush_dec (sq_vec[STG_D]),
        .hold_f    (stall_f),
        .hold_d    (stall_d),
        .bubble_e  (bubble_e)
    );

    // R8: any clear wins over holding decode
    p_flush_over_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|squash) |-> !stall_d && !bubble_e);

    // R3: a bubble is only inserted while the front end is held
    p_bubble_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_e |-> (stall_f && stall_d));

    // R5: no redirect, no clear
    p_no_redir_no_sq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(br_taken || jmp_taken) |-> (squash == '0));

endmodule

// File: tb/hazard_ctrl_tb.sv
`timescale 1ns/1ps
module hazard_ctrl_tb;

    typedef struct packed {
        logic [4:0] rs1;
        logic [4:0] rs2;
        logic [4:0] exr;
        logic       exw;
        logic       exl;
        logic [4:0] mr;
        logic       mw;
        logic [4:0] wr;
        logic       ww;
        logic       br;
        logic       jp;
        logic [1:0] esa;   // default build expectations
        logic [1:0] esb;
        logic       est;
        logic [3:0] esq;
        logic       ast;   // alternate build (stall-only, late resolve)
        logic [3:0] asq;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1, 2, 1, 1, 0, 2, 1, 3, 1, 0, 0, 1, 2, 0, 0, 1, 0},   // R2 ex vs mem, R4
        '{3, 3, 3, 0, 0, 3, 1, 3, 1, 0, 0, 2, 2, 0, 0, 1, 0},   // R2 we gates ex, mem beats wb
        '{5, 6, 5, 0, 0, 5, 0, 6, 1, 0, 0, 0, 3, 0, 0, 1, 0},   // R2 wb only
        '{0, 0, 0, 1, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0},   // R1 x0
        '{7, 8, 8, 1, 1, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 1, 0},   // R3 load-use
        '{0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0},   // R1 load to x0
        '{9, 10, 11, 1, 0, 12, 1, 13, 1, 0, 0, 0, 0, 0, 0, 0, 0}, // no match
        '{1, 2, 4, 1, 0, 4, 1, 4, 1, 1, 0, 0, 0, 0, 7, 0, 15},  // R6 branch
        '{7, 0, 7, 1, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0, 3, 0, 7},   // R7 R8 jump + load-use
        '{1, 2, 4, 0, 0, 4, 0, 4, 0, 1, 1, 0, 0, 0, 7, 0, 15},  // R7 both
        '{4, 0, 4, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}    // R3 no write enable
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] rs1, rs2, exr, mr, wr;
    logic exw, exl, mw, ww, br, jp;

    logic [1:0] d_sa, d_sb, a_sa, a_sb;
    logic d_sf, d_sd, d_be, a_sf, a_sd, a_be;
    logic [3:0] d_sq, a_sq;
    logic d_rv, d_rb, a_rv, a_rb;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    hazard_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .dec_rs1(rs1), .dec_rs2(rs2),
        .ex_rd(exr), .ex_we(exw), .ex_load(exl), .mem_rd(mr), .mem_we(mw),
        .wb_rd(wr), .wb_we(ww), .br_taken(br), .jmp_taken(jp),
        .byp_sel_a(d_sa), .byp_sel_b(d_sb), .stall_f(d_sf), .stall_d(d_sd),
        .bubble_e(d_be), .squash(d_sq), .redir_vld(d_rv), .redir_is_br(d_rb)
    );

    hazard_ctrl #(.USE_BYPASS(1'b0), .BR_AT_WB(1'b1), .JMP_AT_MEM(1'b1)) u_dut_alt (
        .clk(clk), .rst_n(rst_n), .dec_rs1(rs1), .dec_rs2(rs2),
        .ex_rd(exr), .ex_we(exw), .ex_load(exl), .mem_rd(mr), .mem_we(mw),
        .wb_rd(wr), .wb_we(ww), .br_taken(br), .jmp_taken(jp),
        .byp_sel_a(a_sa), .byp_sel_b(a_sb), .stall_f(a_sf), .stall_d(a_sd),
        .bubble_e(a_be), .squash(a_sq), .redir_vld(a_rv), .redir_is_br(a_rb)
    );

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        rs1 = v.rs1; rs2 = v.rs2; exr = v.exr; exw = v.exw; exl = v.exl;
        mr = v.mr; mw = v.mw; wr = v.wr; ww = v.ww; br = v.br; jp = v.jp;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        drive('0);
        br = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R10 redir_vld in reset", {7'd0, d_rv}, 8'd0);
        chk("R10 redir_is_br in reset", {7'd0, d_rb}, 8'd0);
        chk("R10 alt redir_vld in reset", {7'd0, a_rv}, 8'd0);
        @(negedge clk);
        br = 1'b0;
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R9 idle after reset", {7'd0, d_rv}, 8'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            #1;
            chk("R2 sel_a", {6'd0, d_sa}, {6'd0, VECS[i].esa});
            chk("R2 sel_b", {6'd0, d_sb}, {6'd0, VECS[i].esb});
            chk("R3 stall_d", {7'd0, d_sd}, {7'd0, VECS[i].est});
            chk("R3 stall_f", {7'd0, d_sf}, {7'd0, VECS[i].est});
            chk("R3 bubble_e", {7'd0, d_be}, {7'd0, VECS[i].est});
            chk("R5 R6 R7 squash", {4'd0, d_sq}, {4'd0, VECS[i].esq});
            chk("R4 alt sel", {4'd0, a_sa, a_sb}, 8'd0);
            chk("R4 R8 alt stall_d", {7'd0, a_sd}, {7'd0, VECS[i].ast});
            chk("R6 R7 alt squash", {4'd0, a_sq}, {4'd0, VECS[i].asq});
            @(posedge clk); #1;
            chk("R9 redir_vld", {7'd0, d_rv}, {7'd0, VECS[i].br | VECS[i].jp});
            chk("R9 redir_is_br", {7'd0, d_rb}, {7'd0, VECS[i].br});
            chk("R9 alt redir_vld", {7'd0, a_rv}, {7'd0, VECS[i].br | VECS[i].jp});
        end

        // R4: producer of x14 walks execute -> memory -> writeback -> gone
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            drive('0);
            rs1 = 5'd14;
            if (c == 0) begin exr = 5'd14; exw = 1'b1; end
            if (c == 1) begin mr  = 5'd14; mw  = 1'b1; end
            if (c == 2) begin wr  = 5'd14; ww  = 1'b1; end
            #1;
            chk("R4 alt stall window", {7'd0, a_sd}, {7'd0, c < 3});
            chk("R4 alt bubble window", {7'd0, a_be}, {7'd0, c < 3});
            chk("R2 walk sel_a", {6'd0, d_sa}, (c < 3) ? 8'(c + 1) : 8'd0);
            chk("R3 walk no stall", {7'd0, d_sd}, 8'd0);
        end

        // R8: stall-only hazard pending while branch resolves late
        @(negedge clk);
        drive('0);
        rs2 = 5'd9; wr = 5'd9; ww = 1'b1; br = 1'b1;
        #1;
        chk("R8 alt flush beats stall", {7'd0, a_sf}, 8'd0);
        chk("R6 alt branch squash", {4'd0, a_sq}, 8'h0f);
        @(posedge clk); #1;
        chk("R9 alt is_br", {7'd0, a_rb}, 8'd1);

        // R9: strobe lasts a single cycle
        @(negedge clk);
        drive('0);
        @(posedge clk); #1;
        chk("R9 strobe drops", {7'd0, d_rv}, 8'd0);

        finish_run();
    end

endmodule